// File: doc/BRIEF.md
# Double-Buffered Quad DAC Register Bank

This block is the digital front end of a four-channel, 8-bit parallel-input converter. An external controller puts a code on an 8-bit bus and a channel number on a 2-bit address, then pulses an active-low write strobe. The code goes into that channel's first-stage (staging) register. An active-low load strobe then copies all four staging registers into the second-stage (output) registers at once, so the four converter codes change in the same clock. If the load strobe is held low, the bank behaves as a single-stage flow-through path.

The external strobes and the shutdown line are asynchronous. They pass through a two-flop synchronizer on the system clock, and the level-sensitive transparency of both register stages is reproduced one clock at a time. The four output codes are unsigned 8-bit values. A downstream model turns each one into the analog level `code / 256 * Vref`. A per-channel output enable stands in for the buffered analog output stage. It drops during shutdown and comes back only after a programmable recovery time.

Top module: `quad_dac_regbank`

## Requirements
- R1: After `rst_n` is asserted, every staging register and every output code reads 8'h00 and all four `out_en` bits are 1. A reset during operation clears all codes as well.
- R2: `addr` selects the target channel: value 0 writes channel 0 (`dac_code[7:0]`), 1 writes channel 1 (`[15:8]`), 2 writes channel 2 (`[23:16]`) and 3 writes channel 3 (`[31:24]`). The other channels are left untouched.
- R3: While the synchronized write strobe is active, the addressed staging register follows `data_in`. When the strobe is inactive, the register holds. A strobe level first sampled at clock edge k acts at edge k+2.
- R4: While the synchronized load strobe is active, all four output codes take their staging values in the same clock. A load level first sampled at edge k changes the outputs at edge k+2. With the load strobe inactive, the outputs never change.
- R5: With both strobes inactive, no staging register and no output code changes, however many clocks pass.
- R6: With both strobes active, the addressed channel's bus value reaches its output code in the same clock as it reaches its staging register (edge k+2). The other three output codes take their current staging values.
- R7: A high `shdn` drives all four `out_en` bits to 0 two edges after it is first sampled. The output codes are kept through shutdown and recovery.
- R8: After `shdn` falls, `out_en` stays 0 for RECOVER clocks past the synchronized fall. Counted from the first edge that samples `shdn` low, all enables return to 1 at edge RECOVER+2, all together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous assert |
| data_in | input | 8 | Code bus |
| addr | input | 2 | Channel select for writes |
| wr_n | input | 1 | Write strobe, active low, asynchronous |
| ld_n | input | 1 | Load strobe for all channels, active low, asynchronous |
| shdn | input | 1 | Shutdown request, active high, asynchronous |
| dac_code | output | 32 | Four output codes, channel i at bits [8i+7:8i] |
| out_en | output | 4 | Per-channel output enable, 0 means high impedance |

## Verification
The bench sweeps every code through every channel in flow-through mode. It samples the clock before and the clock at the expected edge, so an extra or a missing pipeline stage shows up as a timing mismatch, and a wrong address decode shows up as corruption of a neighbouring channel. A separate case loads stale staging values while a new write to channel 0 is in progress. A design that routed only the addressed data, or that loaded the previous staging value, would leave some channels wrong. The shutdown cases measure the exact clock at which the enables return. They also check that the codes survive, which catches an off-by-one recovery counter and a design that clears its registers on shutdown.

// File: rtl/qdac_pkg.sv
package qdac_pkg;

  typedef enum logic [1:0] {
    BANK_HOLD  = 2'b00,
    BANK_WRITE = 2'b01,
    BANK_LOAD  = 2'b10,
    BANK_FLOW  = 2'b11
  } bank_mode_e;

  function automatic bank_mode_e bank_mode(input logic wr_act, input logic ld_act);
    return bank_mode_e'({ld_act, wr_act});
  endfunction

endpackage

// File: rtl/qdac_sync.sv
module qdac_sync #(
  parameter int unsigned WIDTH   = 3,
  parameter int unsigned STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);

  logic [WIDTH-1:0] stage_q [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      logic [WIDTH-1:0] stage_d;
      if (s == 0) begin : g_first
        assign stage_d = async_in;
      end else begin : g_next
        assign stage_d = stage_q[s-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          stage_q[s] <= RST_VAL;
        end else begin
          stage_q[s] <= stage_d;
        end
      end
    end
  endgenerate

  assign sync_out = stage_q[STAGES-1];

endmodule

// File: rtl/qdac_chan.sv
module qdac_chan
  import qdac_pkg::*;
#(
  parameter int unsigned CODE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  bank_mode_e        mode,
  input  logic              sel,
  input  logic [CODE_W-1:0] bus_data,
  output logic [CODE_W-1:0] stage_code,
  output logic [CODE_W-1:0] out_code
);

  logic [CODE_W-1:0] stage_q, stage_d;
  logic [CODE_W-1:0] out_q, out_d;
  logic              stage_en, out_en;

  always_comb begin
    stage_en = sel && ((mode == BANK_WRITE) || (mode == BANK_FLOW));
    out_en   = (mode == BANK_LOAD) || (mode == BANK_FLOW);
    stage_d  = stage_en ? bus_data : stage_q;
    out_d    = out_en ? stage_d : out_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
      out_q   <= '0;
    end else begin
      if (stage_en) stage_q <= stage_d;
      if (out_en)   out_q   <= out_d;
    end
  end

  assign stage_code = stage_q;
  assign out_code   = out_q;

endmodule

// File: rtl/qdac_oe_ctrl.sv
module qdac_oe_ctrl #(
  parameter int unsigned RECOVER = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic shdn_act,
  output logic enable
);

  localparam int unsigned CNT_W = (RECOVER < 2) ? 1 : $clog2(RECOVER + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(RECOVER);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = shdn_act || (cnt_q != '0);
    if (shdn_act) begin
      cnt_d = CNT_LOAD;
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - 1'b1;
    end else begin
      cnt_d = cnt_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign enable = !shdn_act && (cnt_q == '0);

endmodule

// File: rtl/quad_dac_regbank.sv
module quad_dac_regbank
  import qdac_pkg::*;
#(
  parameter int unsigned CODE_W    = 8,
  parameter int unsigned NUM_CH    = 4,
  parameter int unsigned SYNC_DEPTH = 2,
  parameter int unsigned RECOVER   = 16,
  localparam int unsigned ADDR_W   = (NUM_CH < 2) ? 1 : $clog2(NUM_CH)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [CODE_W-1:0]        data_in,
  input  logic [ADDR_W-1:0]        addr,
  input  logic                     wr_n,
  input  logic                     ld_n,
  input  logic                     shdn,
  output logic [NUM_CH*CODE_W-1:0] dac_code,
  output logic [NUM_CH-1:0]        out_en
);

  localparam int unsigned CTRL_W = 3;

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_pipe_q;
  logic       rst_l_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= '0;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end
  assign rst_l_n = rst_pipe_q[1];

  // control synchronizer: {shdn, ld_n, wr_n}, idle value is strobes high
  logic [CTRL_W-1:0] ctrl_sync;
  logic              wr_act, ld_act, shdn_act;
  bank_mode_e        mode;

  qdac_sync #(
    .WIDTH  (CTRL_W),
    .STAGES (SYNC_DEPTH),
    .RST_VAL(3'b011)
  ) u_sync (
    .clk     (clk),
    .rst_n   (rst_l_n),
    .async_in({shdn, ld_n, wr_n}),
    .sync_out(ctrl_sync)
  );

  assign wr_act   = !ctrl_sync[0];
  assign ld_act   = !ctrl_sync[1];
  assign shdn_act =  ctrl_sync[2];
  assign mode     = bank_mode(wr_act, ld_act);

  logic [NUM_CH*CODE_W-1:0] stage_flat;

  genvar c;
  generate
    for (c = 0; c < NUM_CH; c++) begin : g_chan
      logic sel;
      assign sel = (addr == ADDR_W'(c));
      qdac_chan #(.CODE_W(CODE_W)) u_chan (
        .clk       (clk),
        .rst_n     (rst_l_n),
        .mode      (mode),
        .sel       (sel),
        .bus_data  (data_in),
        .stage_code(stage_flat[c*CODE_W +: CODE_W]),
        .out_code  (dac_code[c*CODE_W +: CODE_W])
      );
    end
  endgenerate

  logic oe_all;

  qdac_oe_ctrl #(.RECOVER(RECOVER)) u_oe (
    .clk     (clk),
    .rst_n   (rst_l_n),
    .shdn_act(shdn_act),
    .enable  (oe_all)
  );

  assign out_en = {NUM_CH{oe_all}};

endmodule

// File: rtl/qdac_checker.sv
module qdac_checker #(
  parameter int unsigned CODE_W = 8,
  parameter int unsigned NUM_CH = 4
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     wr_act,
  input logic                     ld_act,
  input logic                     shdn_act,
  input logic [NUM_CH*CODE_W-1:0] stage_flat,
  input logic [NUM_CH*CODE_W-1:0] dac_code,
  input logic [NUM_CH-1:0]        out_en
);

  a_r3_stage_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_act |=> $stable(stage_flat));

  a_r4_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_act |=> $stable(dac_code));

  a_r4_load_copy: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_act && !wr_act) |=> (dac_code == $past(stage_flat)));

  a_r5_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_act && !ld_act) |=> ($stable(stage_flat) && $stable(dac_code)));

  a_r7_shdn_off: assert property (@(posedge clk) disable iff (!rst_n)
    shdn_act |-> (out_en == '0));

  a_r7_uniform_en: assert property (@(posedge clk) disable iff (!rst_n)
    (out_en == '0) || (&out_en));

  a_r8_recover_low: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(shdn_act) |-> (out_en == '0));

endmodule

bind quad_dac_regbank qdac_checker #(
  .CODE_W(CODE_W),
  .NUM_CH(NUM_CH)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_act    (wr_act),
  .ld_act    (ld_act),
  .shdn_act  (shdn_act),
  .stage_flat(stage_flat),
  .dac_code  (dac_code),
  .out_en    (out_en)
);

// File: tb/tb_quad_dac_regbank.sv
module tb_quad_dac_regbank;

  localparam int CLK_PERIOD = 10;
  localparam int RECOV      = 5;

  logic        clk;
  logic        rst_n;
  logic [7:0]  data_in;
  logic [1:0]  addr;
  logic        wr_n, ld_n, shdn;
  logic [31:0] dac_code;
  logic [3:0]  out_en;

  int checks;
  int errors;
  logic [7:0] expv [4];

  quad_dac_regbank #(.RECOVER(RECOV)) dut (
    .clk(clk), .rst_n(rst_n), .data_in(data_in), .addr(addr),
    .wr_n(wr_n), .ld_n(ld_n), .shdn(shdn),
    .dac_code(dac_code), .out_en(out_en)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: run did not complete, actual hung expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic step();
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] pack_exp();
    return {expv[3], expv[2], expv[1], expv[0]};
  endfunction

  // write with ld_n left as it is; returns at the negedge after edge k+2
  task automatic write_chk(input int ch, input logic [7:0] val, input logic flow, input string req);
    addr = 2'(ch); data_in = val; wr_n = 1'b0;
    step(); wr_n = 1'b1;              // edge k sampled the strobe
    step();                            // after k+1: unchanged
    chk(req, dac_code, pack_exp());
    step();                            // after k+2
    if (flow) expv[ch] = val;
    chk(req, dac_code, pack_exp());
  endtask

  initial begin
    checks = 0; errors = 0;
    rst_n = 1'b0; wr_n = 1'b1; ld_n = 1'b1; shdn = 1'b0;
    data_in = '0; addr = '0;
    for (int i = 0; i < 4; i++) expv[i] = 8'h00;
    repeat (3) step();
    rst_n = 1'b1;
    repeat (5) step();

    // R1: reset state
    chk("R1 codes", dac_code, 32'h0);
    chk("R1 enables", {28'h0, out_en}, 32'h0000_000F);

    // R3 R5: staged writes do not reach the outputs with load inactive
    for (int i = 0; i < 4; i++) write_chk(i, 8'h11 * 8'(i + 1) + 8'h20, 1'b0, "R3 staged write blocked");

    // R4 R2: single load pulse moves all four together at edge k+2
    ld_n = 1'b0;
    step(); ld_n = 1'b1;
    step();
    chk("R4 before edge k+2", dac_code, 32'h0);
    step();
    for (int i = 0; i < 4; i++) expv[i] = 8'h11 * 8'(i + 1) + 8'h20;
    chk("R4 R2 simultaneous load", dac_code, pack_exp());

    // R5: idle hold
    repeat (25) step();
    chk("R5 idle hold", dac_code, pack_exp());

    // R6 R2 R3: exhaustive flow-through sweep with exact timing
    ld_n = 1'b0;
    repeat (4) step();
    for (int ch = 0; ch < 4; ch++) begin
      for (int v = 0; v < 256; v++) begin
        write_chk(ch, 8'(v ^ (ch * 37)), 1'b1, "R6 R2 flow-through sweep");
      end
    end
    ld_n = 1'b1;
    repeat (4) step();

    // R6: both strobes together, other channels pick up stale staging values
    write_chk(1, 8'h5A, 1'b0, "R3 stage ch1");
    write_chk(2, 8'hA5, 1'b0, "R3 stage ch2");
    write_chk(3, 8'h3C, 1'b0, "R3 stage ch3");
    addr = 2'd0; data_in = 8'hC3; wr_n = 1'b0; ld_n = 1'b0;
    step(); wr_n = 1'b1; ld_n = 1'b1;
    step();
    chk("R6 before edge k+2", dac_code, pack_exp());
    step();
    expv[0] = 8'hC3; expv[1] = 8'h5A; expv[2] = 8'hA5; expv[3] = 8'h3C;
    chk("R6 joint strobes", dac_code, pack_exp());

    // R7: shutdown
    shdn = 1'b1;
    step();
    chk("R7 enables after edge k", {28'h0, out_en}, 32'hF);
    step();
    chk("R7 enables off", {28'h0, out_en}, 32'h0);
    repeat (10) step();
    chk("R7 codes kept", dac_code, pack_exp());

    // R8: recovery count
    begin
      int n;
      n = 0;
      shdn = 1'b0;
      do begin
        step(); n++;
      end while (out_en != 4'hF && n < 100);
      chk("R8 recovery edges", 32'(n), 32'(RECOV + 2));
    end
    chk("R7 codes after recovery", dac_code, pack_exp());

    // R1: reset during operation
    rst_n = 1'b0;
    step();
    chk("R1 mid-run reset", dac_code, 32'h0);
    rst_n = 1'b1;
    repeat (5) step();
    chk("R1 enables after reset", {28'h0, out_en}, 32'hF);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule